// File: doc/BRIEF.md
# Two-wire serial EEPROM read slave

This block is the slave side of a two-wire serial memory, limited to reading. It samples the clock line (SCL) and the data line (SDA) and detects START, repeated START and STOP conditions. It compares the 7-bit device address and keeps an 8-bit address pointer into a 256-byte register array. A write-mode address byte followed by one word-address byte loads the pointer; this is the "dummy" write. A repeated START then turns the transfer into a random read. A STOP in the same place only sets the pointer and sends the slave to standby. A read-mode address byte with no dummy write before it reads from the pointer's current value. Every master ACK after a data byte fetches the byte at the next address. The pointer wraps from FFh to 00h. The slave drives SDA open-drain: when `sda_oe` is high the line is pulled low.

The controller is one state machine: IDLE (standby), DEVADDR, DEV_ACK, WADDR, WADDR_ACK, WAIT, TX and MACK.
- A START from any state goes to DEVADDR, and a STOP from any state goes to IDLE.
- In DEVADDR, after eight bits, a matching address goes to DEV_ACK and a mismatch goes to IDLE.
- DEV_ACK goes to TX on a read request and to WADDR on a write request.
- WADDR goes to WADDR_ACK, which loads the pointer.
- WADDR_ACK goes to WAIT, which waits for a repeated START or a STOP.
- TX goes to MACK after eight bits, and the pointer increments.
- MACK goes back to TX on a master ACK and to IDLE on a NACK.

Both lines pass through two-flop synchronisers. Bus events are seen as edges of the synchronised signals. SDA is sampled on SCL rising and the slave changes its SDA drive only while SCL is low.

Top module: `eeprom_rd_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0) and the address pointer is 00h.
- R2: START (SDA falls while SCL is high) starts address reception from any state, including a repeated START inside a transfer. STOP (SDA rises while SCL is high) returns the slave to standby.
- R3: Only the device address 1010000 (bits 7..1 of the first byte, MSB first) is acknowledged. On a mismatch SDA stays released, and every later byte is ignored until the next START.
- R4: A write-mode address byte (A0h) and the word-address byte after it are both acknowledged, and the word address becomes the pointer.
- R5: A repeated START followed by A1h after the word address is acknowledged, and the slave then shifts out, MSB first, the byte at the loaded pointer.
- R6: A STOP after the word-address acknowledge keeps the loaded pointer, and the next read starts at that location.
- R7: A read-mode byte A1h with no dummy write before it reads from the current pointer value.
- R8: After each data byte the pointer increments by one. A master ACK (SDA low in the ninth clock) makes the slave send the byte at the next address.
- R9: After location FFh the pointer rolls over to 00h and output continues.
- R10: A master NACK (SDA high in the ninth clock) ends the read. After that, bytes clocked without a START get no acknowledge, and the pointer stays one past the last byte sent.
- R11: The slave's SDA drive changes only while SCL is low.
- R12: Array location a holds {a[3:0], a[7:4]} XOR 3Ch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND value) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
Two functions can fall in the same cycle: the load of the pointer from the word address, and the START/STOP detector that decides what follows. Between them, the repeated START or STOP that ends the dummy write also decides whether the loaded pointer is used at once or kept for later. The bench provokes both outcomes right after the word-address acknowledge, in directed cases and in random mixes. It judges each outcome by the first data byte returned, then or in a later current-address read. A second overlap is the pointer increment at the end of a byte and the fetch of the next byte on a master ACK. This is exercised by bursts that cross FFh, and those are judged byte by byte against the array content rule.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WAIT,
        ST_TX,
        ST_MACK
    } rd_state_t;

    // Content of array cell a: nibbles swapped, then XOR 3Ch.
    function automatic logic [7:0] cell_init(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'h3C;
    endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             scl_q;
    logic             sda_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = ~scl_q & scl_s;
    assign scl_fall = scl_q & ~scl_s;
    assign start_p  = scl_q & scl_s & sda_q & ~sda_s;
    assign stop_p   = scl_q & scl_s & ~sda_q & sda_s;

endmodule

// File: rtl/rom_array.sv
module rom_array #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= eeprom_rd_pkg::cell_init(8'(i));
            end
        end
    end

    assign rd_data = mem[addr];

endmodule

// File: rtl/eeprom_rd_slave.sv
module eeprom_rd_slave #(
    parameter int         AW          = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import eeprom_rd_pkg::*;

    localparam int                DW    = 8;
    localparam int                CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0]  BITS  = CNT_W'(DW);
    localparam logic [AW-1:0]     ONE   = AW'(1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [7:0] rd_data;

    rd_state_t        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [DW-1:0]    sr, sr_n;
    logic [DW-1:0]    tx_sr, tx_n;
    logic             rw, rw_n;
    logic             got_rise, rise_n;
    logic             mack, mack_n;
    logic [AW-1:0]    ptr, ptr_n;
    logic             oe_n;

    bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    rom_array #(.AW(AW)) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (ptr),
        .rd_data (rd_data)
    );

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        sr_n    = sr;
        tx_n    = tx_sr;
        rw_n    = rw;
        rise_n  = got_rise;
        mack_n  = mack;
        ptr_n   = ptr;
        oe_n    = sda_oe;
        if (stop_p) begin
            state_n = ST_IDLE;
            oe_n    = 1'b0;
        end else if (start_p) begin
            state_n = ST_DEVADDR;
            cnt_n   = '0;
            oe_n    = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: begin
                end
                ST_DEVADDR: begin
                    if (scl_rise && cnt < BITS) begin
                        sr_n  = {sr[DW-2:0], sda_s};
                        cnt_n = cnt + 1'b1;
                    end else if (scl_fall && cnt == BITS) begin
                        if (sr[DW-1:1] == DEV_ADDR) begin
                            state_n = ST_DEV_ACK;
                            rw_n    = sr[0];
                            rise_n  = 1'b0;
                            oe_n    = 1'b1;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_rise) begin
                        rise_n = 1'b1;
                    end else if (scl_fall && got_rise) begin
                        cnt_n = '0;
                        if (rw) begin
                            state_n = ST_TX;
                            tx_n    = rd_data;
                            oe_n    = ~rd_data[7];
                        end else begin
                            state_n = ST_WADDR;
                            oe_n    = 1'b0;
                        end
                    end
                end
                ST_WADDR: begin
                    if (scl_rise && cnt < BITS) begin
                        sr_n  = {sr[DW-2:0], sda_s};
                        cnt_n = cnt + 1'b1;
                    end else if (scl_fall && cnt == BITS) begin
                        state_n = ST_WADDR_ACK;
                        ptr_n   = sr[AW-1:0];
                        rise_n  = 1'b0;
                        oe_n    = 1'b1;
                    end
                end
                ST_WADDR_ACK: begin
                    if (scl_rise) begin
                        rise_n = 1'b1;
                    end else if (scl_fall && got_rise) begin
                        state_n = ST_WAIT;
                        oe_n    = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt_n = cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt == BITS) begin
                            state_n = ST_MACK;
                            ptr_n   = ptr + ONE;
                            rise_n  = 1'b0;
                            oe_n    = 1'b0;
                        end else begin
                            tx_n = {tx_sr[DW-2:0], 1'b0};
                            oe_n = ~tx_sr[DW-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        rise_n = 1'b1;
                        mack_n = ~sda_s;
                    end else if (scl_fall && got_rise) begin
                        if (mack) begin
                            state_n = ST_TX;
                            cnt_n   = '0;
                            tx_n    = rd_data;
                            oe_n    = ~rd_data[7];
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sr       <= '0;
            tx_sr    <= '0;
            rw       <= 1'b0;
            got_rise <= 1'b0;
            mack     <= 1'b0;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            sr       <= sr_n;
            tx_sr    <= tx_n;
            rw       <= rw_n;
            got_rise <= rise_n;
            mack     <= mack_n;
        end
    end

    // Output process: SDA drive and address pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
            ptr    <= '0;
        end else begin
            sda_oe <= oe_n;
            ptr    <= ptr_n;
        end
    end

    // R11
    sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R10
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R8
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_MACK) |-> (ptr == $past(ptr) + ONE));

    // R3
    dev_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> (sr[DW-1:1] == DEV_ADDR));

    // R2
    start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> (state == ST_DEVADDR));

endmodule

// File: tb/eeprom_rd_slave_bench.sv
module eeprom_rd_slave_bench;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mscl = 1'b1;
    logic msda = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic prev_oe = 1'b0;
    logic [7:0] mptr = 8'h00;
    int vectors = 0;
    int miscompares = 0;
    int edge_viol = 0;
    int seed_dummy;

    assign sda_line = msda & ~sda_oe;

    always #10 clk = ~clk;

    eeprom_rd_slave u_eeprom_rd_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (mscl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    // R11 monitor: drive must not change while SCL is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && mscl) edge_viol++;
        prev_oe = sda_oe;
    end

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic q(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start;
        msda = 1'b1; q();
        mscl = 1'b1; q();
        msda = 1'b0; q();
        mscl = 1'b0; q();
    endtask

    task automatic bus_stop;
        msda = 1'b0; q();
        mscl = 1'b1; q();
        msda = 1'b1; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            q(); msda = b[i]; q();
            mscl = 1'b1; q(2);
            mscl = 1'b0;
        end
        q(); msda = 1'b1; q();
        mscl = 1'b1; q();
        acked = (sda_line == 1'b0);
        q(); mscl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        msda = 1'b1;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            q(2); mscl = 1'b1; q();
            d = {d[6:0], sda_line};
            q(); mscl = 1'b0;
        end
        q(); msda = give_ack ? 1'b0 : 1'b1; q();
        mscl = 1'b1; q(2);
        mscl = 1'b0;
        q(); msda = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] a, input bit with_stop);
        bit ak;
        bus_start;
        send_byte(8'hA0, ak);
        chk(ak, "R4 write-mode address ack", ak, 1);
        send_byte(a, ak);
        chk(ak, "R4 word-address ack", ak, 1);
        mptr = a;
        if (with_stop) bus_stop;
    endtask

    task automatic do_read(input bit random_mode, input logic [7:0] a, input int n);
        bit ak;
        logic [7:0] d;
        logic [7:0] e;
        if (random_mode) set_ptr(a, 1'b0);
        bus_start;
        send_byte(8'hA1, ak);
        chk(ak, random_mode ? "R5 read ack after repeated START (R2)" : "R7 read ack", ak, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            e = exp_byte(mptr);
            chk(d == e,
                (k > 0 && mptr == 8'h00) ? "R9 wrap to 00h" :
                (k > 0) ? "R8 sequential byte" :
                random_mode ? "R5 random read data (R12)" : "R7 current read data (R12)",
                d, e);
            mptr = mptr + 8'h01;
        end
        bus_stop;
    endtask

    task automatic bad_dev(input logic [7:0] b);
        bit ak;
        bus_start;
        send_byte(b, ak);
        chk(!ak, "R3 mismatched address not acked", ak, 0);
        send_byte(8'h33, ak);
        chk(!ak, "R3 byte after mismatch ignored", ak, 0);
        bus_stop;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        bit ak;
        logic [7:0] d;
        int op, len;
        logic [7:0] a, b;
        seed_dummy = $urandom(32'd20250);

        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R1 released during reset", sda_oe, 0);
        rst_n = 1'b1;
        q(2);
        chk(sda_line == 1'b1, "R1 released after reset", sda_line, 1);

        // R1: first current read returns location 00h
        bus_start;
        send_byte(8'hA1, ak);
        chk(ak, "R1 read ack", ak, 1);
        recv_byte(1'b0, d);
        chk(d == exp_byte(8'h00), "R1 pointer starts at 00h", d, exp_byte(8'h00));
        bus_stop;
        mptr = 8'h01;

        // R6: set-current-address then current read
        set_ptr(8'h40, 1'b1);
        bus_start;
        send_byte(8'hA1, ak);
        chk(ak, "R6 read ack", ak, 1);
        recv_byte(1'b0, d);
        chk(d == exp_byte(8'h40), "R6 pointer kept after STOP", d, exp_byte(8'h40));
        bus_stop;
        mptr = 8'h41;

        // R9: burst across the top of the array
        do_read(1'b1, 8'hFE, 4);

        // R10: standby ignores bytes clocked without START
        mscl = 1'b0; q();
        send_byte(8'hA1, ak);
        chk(!ak, "R10 byte in standby ignored", ak, 0);
        send_byte(8'hA0, ak);
        chk(!ak, "R10 second byte in standby ignored", ak, 0);
        bus_start;
        send_byte(8'hA1, ak);
        chk(ak, "R10 read ack", ak, 1);
        recv_byte(1'b0, d);
        chk(d == exp_byte(mptr), "R10 pointer one past last byte", d, exp_byte(mptr));
        bus_stop;
        mptr = mptr + 8'h01;

        // R3: mismatched addresses, pointer left intact
        bad_dev(8'hA2);
        bad_dev(8'h20);
        do_read(1'b0, 8'h00, 2);

        for (int it = 0; it < 30; it++) begin
            op  = $urandom % 4;
            len = 1 + ($urandom % 4);
            a   = ($urandom % 3 == 0) ? (8'hFC | 8'($urandom % 4)) : 8'($urandom);
            unique case (op)
                0: do_read(1'b1, a, len);
                1: do_read(1'b0, 8'h00, len);
                2: set_ptr(a, 1'b1);
                default: begin
                    b = 8'($urandom);
                    if (b[7:1] == 7'h50) b[7] = 1'b0;
                    bad_dev(b);
                end
            endcase
        end
        do_read(1'b0, 8'h00, 3);

        chk(edge_viol == 0, "R11 drive changes only with SCL low", edge_viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule